// File: doc/BRIEF.md
# Three-Byte Framed SPI Slave

This block is an SPI slave (SCK idle low; data captured on rising SCK, driven on falling SCK). Every exchange is exactly three bytes long. The host supplies all clocking. The block samples SCK, the active-low select and MOSI with its own system clock. Each host byte is shifted in most significant bit first. The three bytes are written to a 24-bit configuration output together, and only when the third byte completes. While this happens, three status bytes taken from an input port are shifted out on MISO.

A watchdog timer starts at the first sampled rising SCK edge of an exchange. If all three bytes have not arrived within `TIMEOUT_CYC` system clocks, the partial exchange is dropped, an error pulse is issued and the byte position returns to byte 1. The select may be raised between bytes or held low without breaking the frame. A low select also raises a stay-awake output for as long as it lasts.

Top module: `tri_byte_spi_slave`

## Requirements
- R1: After reset, cfg_o is 0, done_o and err_o are 0, miso_o is 0 and miso_oe_o is 0.
- R2: MOSI is sampled on rising SCK edges, most significant bit first. After the third byte, cfg_o holds {byte1, byte2, byte3}, with byte 1 in bits [23:16], and done_o pulses for exactly one clock.
- R3: While select is low, MISO carries status byte k of the exchange, most significant bit first, and changes on falling SCK edges. Byte 1 comes from status_i[23:16], byte 2 from [15:8] and byte 3 from [7:0].
- R4: Raising select between completed bytes and lowering it again does not break the frame. The next byte is taken as the following byte position.
- R5: cfg_o does not change after one or two bytes of an exchange. It changes only in the cycle in which done_o is high.
- R6: If three bytes are not complete within TIMEOUT_CYC clocks of the first rising SCK edge, err_o pulses for one clock and cfg_o is left unchanged. The next byte received is byte 1 of a new exchange.
- R7: awake_o is high exactly while the synchronized select is low. While select is high, miso_oe_o is 0 and miso_o is 0.
- R8: Raising select in the middle of a byte discards the bits received so far in that byte. The next byte starts again from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| ss_ni | input | 1 | Slave select from host, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for MISO pad |
| status_i | input | 24 | Three status bytes to return, byte 1 in the top bits |
| cfg_o | output | 24 | Last complete host frame, byte 1 in the top bits |
| done_o | output | 1 | One-clock pulse when a frame commits |
| err_o | output | 1 | One-clock pulse when an exchange times out |
| awake_o | output | 1 | High while select is low |

## Verification
Pin inputs pass through two synchronizer flops. An edge is detected against one more stored copy of SCK. As a result:
- a rising SCK edge is seen about three clocks after the pin changes;
- the byte-complete strobe follows one clock later;
- cfg_o and done_o move one clock after that;
- MISO settles about four clocks after a falling SCK edge;
- awake_o and miso_oe_o follow the select pin after two clocks.

The bench holds each SCK half-period for eight clocks. It samples MISO just before raising SCK and reads outputs on the falling system clock edge. Frame results are checked at least ten clocks after the last SCK edge. Pulse outputs are counted by a monitor, so a missed or doubled pulse shows up whatever cycle it lands in.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_W     = BYTE_W * FRAME_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tbs_sync.sv
module tbs_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/tbs_shift.sv
module tbs_shift
  import tbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sck_s_i,
  input  logic  ss_s_i,
  input  logic  mosi_s_i,
  input  logic  abort_i,
  input  byte_t tx_byte_i,
  output logic  bit_rise_o,
  output logic  byte_valid_o,
  output byte_t rx_byte_o,
  output logic  miso_bit_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic             sck_q;
  logic [CNT_W-1:0] bit_cnt_q;
  byte_t            rx_sh_q, tx_sh_q;
  logic             valid_q;
  logic             rise, fall, last_bit;

  assign rise     = sck_s_i & ~sck_q & ~ss_s_i;
  assign fall     = ~sck_s_i & sck_q & ~ss_s_i;
  assign last_bit = (bit_cnt_q == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      sck_q   <= sck_s_i;
      valid_q <= rise & last_bit & ~abort_i;
      if (ss_s_i || abort_i)  bit_cnt_q <= '0;
      else if (rise)          bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;
      if (rise) rx_sh_q <= {rx_sh_q[BYTE_W-2:0], mosi_s_i};
      // hold the fresh status byte until the first bit is taken
      if (bit_cnt_q == '0) tx_sh_q <= tx_byte_i;
      else if (fall)       tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign bit_rise_o   = rise;
  assign byte_valid_o = valid_q;
  assign rx_byte_o    = rx_sh_q;
  assign miso_bit_o   = tx_sh_q[BYTE_W-1];

  // R8
  ss_clears_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s_i |=> (bit_cnt_q == '0));
  // R2
  byte_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !$past(ss_s_i));
  // R2
  byte_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
endmodule

// File: rtl/tbs_frame.sv
module tbs_frame
  import tbs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_rise_i,
  input  logic               byte_valid_i,
  input  byte_t              rx_byte_i,
  output logic [IDX_W-1:0]   byte_idx_o,
  output logic [FRAME_W-1:0] cfg_o,
  output logic               done_o,
  output logic               err_o,
  output logic               abort_o
);
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int HOLD_W = FRAME_W - BYTE_W;

  logic [IDX_W-1:0]   idx_q;
  logic [TMR_W-1:0]   tmr_q;
  logic               active_q, done_q, err_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [FRAME_W-1:0] cfg_q;
  logic               last_in, timeout_hit;

  assign last_in     = byte_valid_i & (idx_q == IDX_W'(FRAME_BYTES-1));
  assign timeout_hit = active_q & (tmr_q == TMR_W'(TIMEOUT_CYC-1)) & ~last_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      tmr_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      hold_q   <= '0;
      cfg_q    <= '0;
    end else begin
      done_q <= last_in;
      err_q  <= timeout_hit;
      if (timeout_hit) begin
        idx_q    <= '0;
        active_q <= 1'b0;
        tmr_q    <= '0;
      end else if (last_in) begin
        cfg_q    <= {hold_q, rx_byte_i};
        idx_q    <= '0;
        active_q <= 1'b0;
        tmr_q    <= '0;
      end else begin
        if (byte_valid_i) begin
          hold_q <= {hold_q[HOLD_W-BYTE_W-1:0], rx_byte_i};
          idx_q  <= idx_q + 1'b1;
        end
        if (active_q)        tmr_q <= tmr_q + 1'b1;
        else if (bit_rise_i) begin
          active_q <= 1'b1;
          tmr_q    <= '0;
        end
      end
    end
  end

  assign byte_idx_o = idx_q;
  assign cfg_o      = cfg_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign abort_o    = timeout_hit;

  // R5
  cfg_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> done_q);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && err_q));
  // R6
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q < TMR_W'(TIMEOUT_CYC));
  // R6
  err_resets_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (idx_q == '0));
  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(FRAME_BYTES));
endmodule

// File: rtl/tri_byte_spi_slave.sv
module tri_byte_spi_slave
  import tbs_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int TIMEOUT_CYC = CLK_HZ / 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               ss_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  input  logic [FRAME_W-1:0] status_i,
  output logic [FRAME_W-1:0] cfg_o,
  output logic               done_o,
  output logic               err_o,
  output logic               awake_o
);
  logic             sck_s, ss_s, mosi_s;
  logic             bit_rise, byte_valid, abort, miso_bit;
  byte_t            rx_byte, tx_byte;
  logic [IDX_W-1:0] byte_idx;

  tbs_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   ({sck_s, ss_s, mosi_s})
  );

  always_comb begin
    tx_byte = '0;
    for (int k = 0; k < FRAME_BYTES; k++)
      if (byte_idx == IDX_W'(k))
        tx_byte = status_i[(FRAME_BYTES-1-k)*BYTE_W +: BYTE_W];
  end

  tbs_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_s_i     (sck_s),
    .ss_s_i      (ss_s),
    .mosi_s_i    (mosi_s),
    .abort_i     (abort),
    .tx_byte_i   (tx_byte),
    .bit_rise_o  (bit_rise),
    .byte_valid_o(byte_valid),
    .rx_byte_o   (rx_byte),
    .miso_bit_o  (miso_bit)
  );

  tbs_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_rise_i  (bit_rise),
    .byte_valid_i(byte_valid),
    .rx_byte_i   (rx_byte),
    .byte_idx_o  (byte_idx),
    .cfg_o       (cfg_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .abort_o     (abort)
  );

  assign miso_oe_o = ~ss_s;
  assign miso_o    = ~ss_s & miso_bit;
  assign awake_o   = ~ss_s;

  // R7
  miso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ss_ni, 2) && $past(ss_ni, 3) |-> !miso_o && !miso_oe_o);
endmodule

// File: tb/tri_byte_spi_slave_tb.sv
module tri_byte_spi_slave_tb;
  localparam int TO  = 3000;
  localparam int H   = 8;
  localparam int NV  = 4;
  // {host frame, status frame, raise select between bytes}
  localparam logic [48:0] VEC [NV] = '{
    {24'hA5_3C_0F, 24'h81_7E_C3, 1'b0},
    {24'h00_FF_12, 24'h5A_00_FF, 1'b1},
    {24'hDE_AD_BE, 24'h01_80_55, 1'b1},
    {24'h69_96_C0, 24'hF0_0F_AA, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [23:0] status = '0;
  logic        miso, miso_oe, done, err, awake;
  logic [23:0] cfg;
  int          errs = 0, checks = 0, done_n = 0, err_n = 0;

  always #2.5 clk = ~clk;

  tri_byte_spi_slave #(.TIMEOUT_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .status_i(status), .cfg_o(cfg),
    .done_o(done), .err_o(err), .awake_o(awake)
  );

  always @(negedge clk) begin
    if (rst_n && done) done_n++;
    if (rst_n && err)  err_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
    wait_clk(H);
  endtask

  task automatic send_bytes(input logic [23:0] host, input int nb, input logic gap,
                            output logic [23:0] got);
    logic [7:0] r;
    got = '0;
    ss_n = 1'b0;
    wait_clk(8);
    for (int b = 0; b < nb; b++) begin
      xfer_bits(host[23-8*b -: 8], 8, r);
      got[23-8*b -: 8] = r;
      if (gap && b < nb - 1) begin
        ss_n = 1'b1;
        wait_clk(6);
        ss_n = 1'b0;
        wait_clk(8);
      end
    end
    wait_clk(10);
    ss_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [23:0] got, last_cfg;
    int d0, e0;
    wait_clk(3);
    // R1
    chk("R1 cfg", cfg, 0);
    chk("R1 done/err", {done, err}, 0);
    chk("R1 miso/oe", {miso, miso_oe}, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R2 R3 R4: vector table
    for (int v = 0; v < NV; v++) begin
      d0 = done_n;
      status = VEC[v][24:1];
      send_bytes(VEC[v][48:25], 3, VEC[v][0], got);
      chk("R2 cfg", cfg, VEC[v][48:25]);
      chk("R2 done pulse", done_n - d0, 1);
      chk("R3 miso bytes", got, VEC[v][24:1]);
      if (VEC[v][0]) chk("R4 gap frame", cfg, VEC[v][48:25]);
    end

    // R7
    ss_n = 1'b0;
    wait_clk(4);
    chk("R7 awake low sel", {awake, miso_oe}, 2'b11);
    ss_n = 1'b1;
    wait_clk(4);
    chk("R7 awake high sel", {awake, miso_oe, miso}, 0);

    // R5 partial frame, then R6 timeout
    last_cfg = cfg;
    d0 = done_n;
    e0 = err_n;
    send_bytes(24'h11_22_33, 2, 1'b0, got);
    chk("R5 cfg after 2 bytes", cfg, last_cfg);
    chk("R5 no done", done_n - d0, 0);
    wait_clk(TO);
    chk("R6 err pulse", err_n - e0, 1);
    chk("R6 cfg kept", cfg, last_cfg);
    status = 24'h3C_C3_96;
    send_bytes(24'h44_55_66, 3, 1'b0, got);
    chk("R6 restart at byte 1", cfg, 24'h44_55_66);
    chk("R6 status restart", got, 24'h3C_C3_96);
    chk("R6 single err", err_n - e0, 1);

    // R8 mid-byte select raise
    d0 = done_n;
    ss_n = 1'b0;
    wait_clk(8);
    xfer_bits(8'hF0, 4, got[7:0]);
    ss_n = 1'b1;
    wait_clk(10);
    send_bytes(24'h0A_0B_0C, 3, 1'b0, got);
    chk("R8 aligned frame", cfg, 24'h0A_0B_0C);
    chk("R8 one done", done_n - d0, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule